// File: doc/BRIEF.md
# Ethernet receive destination address filter

This block decides whether an incoming Ethernet frame is for this station. It sits behind the receive decoder, which hands it the destination address of each frame one bit per clock, least significant bit first. The first bit of a frame is flagged with a start strobe. When the 48th bit has been taken in, the block gives one accept or reject verdict for that frame.

The filter compares the incoming address bit by bit against a programmable station address. It also tracks whether every bit seen so far has been one, which marks the broadcast address. A mode register can force acceptance of every frame. It can also withhold acceptance of broadcast frames, or of frames that match the station address, and these two controls are independent.

The host programs the station address and the mode through a small register bus. The station address is held in three 16-bit words. The registers can only be changed while the host holds the halt input high. Reset clears the mode register, but it leaves the station address as it was.

Top module: `dest_addr_filter`

## Requirements
- R1: The station address occupies register addresses 0, 1 and 2, holding address bits 15:0, 31:16 and 47:32 respectively; a read returns the last value written, on `reg_rdata` one clock after `reg_addr` is presented.
- R2: The mode register sits at register address 3 and reads back all 16 written bits; bit 15 is promiscuous, bit 14 is broadcast-disable, bit 13 is station-match-disable, and the other bits have no effect on filtering.
- R3: A write (`reg_we` high) to any register while `halt` is low is ignored and leaves both the register contents and the filtering unchanged.
- R4: Reset clears the mode register to zero, which turns promiscuous mode off and enables broadcast and station matching; reset does not alter the station address registers.
- R5: Destination bits are taken only in cycles where `rx_valid` is high; `rx_sof` high together with `rx_valid` marks address bit 0, and each later valid bit carries the next higher address bit, so idle cycles inside a frame do not disturb the comparison.
- R6: `res_valid` is high for exactly one cycle, the cycle after the clock edge that samples the 48th destination bit, and `res_accept` holds the verdict in that cycle.
- R7: With mode bit 13 clear, a destination equal to the station address is accepted; a difference in any single bit, including bit 0 or bit 47, gives a reject unless another rule accepts.
- R8: With mode bit 14 clear, the all-ones destination is accepted; with bit 14 set it is not accepted on that basis.
- R9: With mode bit 15 set, every frame is accepted whatever its destination and whatever bits 14 and 13 hold.
- R10: A new `rx_sof` restarts the bit count and both match flags, even in the middle of a frame, and the abandoned frame produces no verdict.
- R11: A read of any register address from 4 upward returns zero.
- R12: Valid bits that arrive without a frame in progress, with no `rx_sof` since the last verdict, are ignored and produce no verdict.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt | input | 1 | Register write permission; writes take effect only while high |
| reg_addr | input | 3 | Register select |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data for `reg_addr` |
| rx_valid | input | 1 | A destination bit is present on `rx_bit` |
| rx_sof | input | 1 | The present bit is address bit 0 of a new frame |
| rx_bit | input | 1 | Serial destination address bit |
| res_valid | output | 1 | One-cycle verdict strobe |
| res_accept | output | 1 | Verdict: 1 accept, 0 reject; valid with `res_valid` |

## Verification
The bench flips bit 0 and bit 47 of the station address separately. A comparator that walks the bits in the wrong order, or that stops one bit short, accepts one of these near-miss frames. Each mode bit is also tried alone and in combination, so a priority inverted between promiscuous, broadcast-disable and station-disable shows up as a wrong verdict.

Further tests abort a frame after 20 bits and restart it, insert idle cycles between bits, and feed stray bits with no start strobe. A counter that does not restart, or that ignores `rx_valid`, gives a verdict that is early, missing or extra. Writes with `halt` low, and reset after the registers have been programmed, catch a lockout that leaks and a reset that wipes the station address.

// File: rtl/daf_pkg.sv
package daf_pkg;
  // register map
  localparam int unsigned REG_STA0 = 0;
  localparam int unsigned REG_MODE = 3;
  // mode bit positions
  localparam int unsigned MODE_PROMISC = 15;
  localparam int unsigned MODE_NO_BC   = 14;
  localparam int unsigned MODE_NO_STA  = 13;
endpackage

// File: rtl/daf_regs.sv
module daf_regs #(
  parameter int unsigned REG_W = 16,
  parameter int unsigned NREGS = 3,
  parameter int unsigned RA_W  = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   halt,
  input  logic [RA_W-1:0]        addr,
  input  logic                   we,
  input  logic [REG_W-1:0]       wdata,
  output logic [REG_W-1:0]       rdata,
  output logic [NREGS*REG_W-1:0] station,
  output logic [REG_W-1:0]       mode
);
  localparam int unsigned MODE_ADDR = NREGS;

  logic wr_ok;
  assign wr_ok = we & halt;

  // station words: no reset, hold until written
  for (genvar g = 0; g < NREGS; g++) begin : g_sta
    always_ff @(posedge clk) begin
      if (wr_ok && addr == RA_W'(g))
        station[g*REG_W +: REG_W] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      mode <= '0;
    else if (wr_ok && addr == RA_W'(MODE_ADDR))
      mode <= wdata;
  end

  logic [REG_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NREGS; i++)
      if (addr == RA_W'(i)) rd_mux = station[i*REG_W +: REG_W];
    if (addr == RA_W'(MODE_ADDR)) rd_mux = mode;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/daf_match.sv
module daf_match #(
  parameter int unsigned ADDR_BITS = 48,
  parameter int unsigned CNT_W     = $clog2(ADDR_BITS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_valid,
  input  logic                 rx_sof,
  input  logic                 rx_bit,
  input  logic [ADDR_BITS-1:0] station,
  input  logic                 promisc,
  input  logic                 no_bc,
  input  logic                 no_sta,
  output logic                 res_valid,
  output logic                 res_accept
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BITS - 1);

  logic [CNT_W-1:0] cnt_q, idx;
  logic             active_q, ones_q, eq_q;
  logic             take, ones_n, eq_n, last;

  always_comb begin
    take   = rx_valid & (rx_sof | active_q);
    idx    = rx_sof ? '0 : cnt_q;
    ones_n = (rx_sof | ones_q) & rx_bit;
    eq_n   = (rx_sof | eq_q) & (rx_bit == station[idx]);
    last   = (idx == LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      active_q   <= 1'b0;
      ones_q     <= 1'b0;
      eq_q       <= 1'b0;
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
    end else begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      if (take) begin
        ones_q   <= ones_n;
        eq_q     <= eq_n;
        cnt_q    <= idx + 1'b1;
        active_q <= ~last;
        if (last) begin
          res_valid  <= 1'b1;
          res_accept <= promisc | (ones_n & ~no_bc) | (eq_n & ~no_sta);
        end
      end
    end
  end
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
  import daf_pkg::*;
#(
  parameter int unsigned ADDR_BITS = 48,
  parameter int unsigned REG_W     = 16,
  parameter int unsigned RA_W      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halt,
  input  logic [RA_W-1:0]  reg_addr,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             rx_valid,
  input  logic             rx_sof,
  input  logic             rx_bit,
  output logic             res_valid,
  output logic             res_accept
);
  localparam int unsigned NREGS = ADDR_BITS / REG_W;

  logic [ADDR_BITS-1:0] station_q;
  logic [REG_W-1:0]     mode_q;

  daf_regs #(.REG_W(REG_W), .NREGS(NREGS), .RA_W(RA_W)) u_regs (
    .clk(clk), .rst(rst), .halt(halt), .addr(reg_addr), .we(reg_we),
    .wdata(reg_wdata), .rdata(reg_rdata), .station(station_q), .mode(mode_q)
  );

  daf_match #(.ADDR_BITS(ADDR_BITS)) u_match (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_bit(rx_bit),
    .station(station_q), .promisc(mode_q[MODE_PROMISC]),
    .no_bc(mode_q[MODE_NO_BC]), .no_sta(mode_q[MODE_NO_STA]),
    .res_valid(res_valid), .res_accept(res_accept)
  );
endmodule

// File: rtl/daf_chk.sv
module daf_chk #(
  parameter int unsigned ADDR_BITS = 48,
  parameter int unsigned REG_W     = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 halt,
  input logic                 reg_we,
  input logic                 rx_valid,
  input logic [ADDR_BITS-1:0] station_q,
  input logic [REG_W-1:0]     mode_q,
  input logic                 res_valid,
  input logic                 res_accept
);
  // R3
  lockout_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && !halt) |=> $stable(mode_q));
  // R3
  lockout_sta_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && !halt) |=> $stable(station_q));
  // R4
  reset_mode_chk: assert property (@(posedge clk) rst |=> (mode_q == '0));
  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
  // R6
  after_bit_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(rx_valid));
  // R9
  promisc_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past(mode_q[15])) |-> res_accept);
  // R8
  bc_block_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past(mode_q[15:13]) == 3'b011) |-> !res_accept);
endmodule

bind dest_addr_filter daf_chk #(.ADDR_BITS(ADDR_BITS), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst(rst), .halt(halt), .reg_we(reg_we), .rx_valid(rx_valid),
  .station_q(station_q), .mode_q(mode_q), .res_valid(res_valid),
  .res_accept(res_accept)
);

// File: tb/dest_addr_filter_test.sv
`timescale 1ns/1ps
module dest_addr_filter_test;
  logic        clk = 1'b0;
  logic        rst, halt, reg_we, rx_valid, rx_sof, rx_bit;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        res_valid, res_accept;

  int tests = 0, fails = 0, pulses = 0;

  localparam logic [47:0] STA  = 48'h1234_5678_9ABC;
  localparam logic [47:0] ONES = 48'hFFFF_FFFF_FFFF;
  // {mode, destination, expected accept}
  localparam int NV = 11;
  localparam logic [64:0] VEC [NV] = '{
    {16'h0000, STA,                  1'b1},  // R7 match
    {16'h0000, ONES,                 1'b1},  // R8 broadcast
    {16'h0000, 48'h1234_5678_9ABD,   1'b0},  // R7 bit 0 differs
    {16'h0000, 48'h9234_5678_9ABC,   1'b0},  // R7 bit 47 differs
    {16'h4000, ONES,                 1'b0},  // R8 broadcast disabled
    {16'h4000, STA,                  1'b1},  // R8 station still ok
    {16'h2000, STA,                  1'b0},  // R7 station disabled
    {16'h2000, ONES,                 1'b1},  // R8 broadcast still ok
    {16'h8000, 48'h0000_0000_0001,   1'b1},  // R9 promiscuous
    {16'h6000, STA,                  1'b0},  // R7 both disabled
    {16'hE000, ONES,                 1'b1}   // R9 overrides
  };

  dest_addr_filter uut (
    .clk(clk), .rst(rst), .halt(halt), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
    .rx_sof(rx_sof), .rx_bit(rx_bit), .res_valid(res_valid),
    .res_accept(res_accept)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd_check(input logic [2:0] a, input logic [15:0] exp,
                          input string req);
    @(negedge clk); reg_addr = a;
    @(negedge clk); check(reg_rdata == exp, req, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic drive_bits(input logic [47:0] d, input int n, input bit gap,
                            input bit sof_en);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (res_valid) pulses++;
      rx_valid = 1'b1; rx_sof = sof_en && (i == 0); rx_bit = d[i];
      if (gap && (i % 8 == 7) && (i < n - 1)) begin
        @(negedge clk);
        if (res_valid) pulses++;
        rx_valid = 1'b0; rx_sof = 1'b0;
      end
    end
  endtask

  task automatic finish_frame(input bit exp, input string req);
    @(negedge clk); rx_valid = 1'b0; rx_sof = 1'b0;
    check(pulses == 0, {req, " no early verdict"}, 64'(pulses), 64'd0);
    check(res_valid === 1'b1 && res_accept === exp, req,
          {62'd0, res_valid, res_accept}, {62'd0, 1'b1, exp});
    @(negedge clk);
    check(res_valid === 1'b0, "R6 single pulse", 64'(res_valid), 64'd0);
    pulses = 0;
  endtask

  task automatic frame(input logic [47:0] d, input bit exp, input string req);
    pulses = 0;
    drive_bits(d, 48, 1'b0, 1'b1);
    finish_frame(exp, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; halt = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    rx_valid = 1'b0; rx_sof = 1'b0; rx_bit = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(res_valid === 1'b0, "R6 idle after reset", 64'(res_valid), 64'd0);
    rd_check(3'd3, 16'h0000, "R4 mode cleared");

    // program station
    halt = 1'b1;
    wr(3'd0, STA[15:0]); wr(3'd1, STA[31:16]); wr(3'd2, STA[47:32]);
    rd_check(3'd0, STA[15:0],  "R1 word0");
    rd_check(3'd1, STA[31:16], "R1 word1");
    rd_check(3'd2, STA[47:32], "R1 word2");
    wr(3'd3, 16'h1FFF);
    rd_check(3'd3, 16'h1FFF, "R2 mode readback");
    frame(STA, 1'b1, "R2 low mode bits inert");
    rd_check(3'd5, 16'h0000, "R11 unused addr 5");
    rd_check(3'd7, 16'h0000, "R11 unused addr 7");

    // vector table
    for (int v = 0; v < NV; v++) begin
      wr(3'd3, VEC[v][64:49]);
      frame(VEC[v][48:1], VEC[v][0], $sformatf("R7/R8/R9 vector %0d", v));
    end

    // write lockout
    wr(3'd3, 16'h0000);
    halt = 1'b0;
    wr(3'd3, 16'h8000);
    wr(3'd0, 16'h0000);
    halt = 1'b1;
    rd_check(3'd3, 16'h0000, "R3 mode locked");
    rd_check(3'd0, STA[15:0], "R3 station locked");
    frame(48'h0000_0000_0001, 1'b0, "R3 promisc not enabled");
    frame(STA, 1'b1, "R3 station intact");

    // reset keeps station, clears mode
    wr(3'd3, 16'h6000);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd_check(3'd3, 16'h0000, "R4 mode reset");
    rd_check(3'd2, STA[47:32], "R4 station kept");
    frame(ONES, 1'b1, "R4 broadcast enabled after reset");

    // restart mid-frame
    pulses = 0;
    drive_bits(48'h0000_0000_0000, 20, 1'b0, 1'b1);
    drive_bits(STA, 48, 1'b0, 1'b1);
    finish_frame(1'b1, "R10 restart");

    // idle gaps inside frame
    pulses = 0;
    drive_bits(STA, 48, 1'b1, 1'b1);
    finish_frame(1'b1, "R5 gaps match");
    pulses = 0;
    drive_bits(48'h1234_5678_9ABD, 48, 1'b1, 1'b1);
    finish_frame(1'b0, "R5 gaps mismatch");

    // stray bits without start strobe
    pulses = 0;
    drive_bits(STA, 48, 1'b0, 1'b0);
    drive_bits(STA, 12, 1'b0, 1'b0);
    @(negedge clk); rx_valid = 1'b0;
    if (res_valid) pulses++;
    @(negedge clk);
    if (res_valid) pulses++;
    check(pulses == 0, "R12 stray bits ignored", 64'(pulses), 64'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule